// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM that has an 18-bit word address, an 8-bit data bus and four control strobes. The strobes are a low-true select, a high-true select, a low-true output enable and a low-true write enable. The host hands over one word access at a time through a valid/ready handshake. The controller then plays out the strobe sequence for that access. Each timing interval is held for a whole number of clock cycles, and that number is worked out at elaboration from the clock period parameter and the RAM's nanosecond limits.

A read keeps the RAM selected with the output enable low for long enough to cover both the address access time and the output-enable access time, and never less than the minimum cycle time. The data bus is sampled at the closing edge of that window, and the word is returned to the host with a one-cycle valid pulse. A write keeps the output enable high throughout. It drives the data bus and holds the write enable low for the longest of the pulse-width, address-to-end, data-setup and cycle limits. The bus drivers are released on the same edge that lifts the write enable. When a write follows a read, the controller first keeps the RAM deselected with the drivers off. This lets the RAM's outputs reach high impedance before the controller drives the bus.

The bus is split into an output word, an input word and a drive enable, which the pad ring combines into the bidirectional pins.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, the RAM is deselected (low-true select = 1, high-true select = 0), the output enable and write enable are both 1, the bus drive enable is 0, and ready is 1.
- R2: The two selects always change together. The RAM is selected only when the low-true select is 0 and the high-true select is 1, and only during the active phase of an access.
- R3: A read starts in the cycle after acceptance and holds select, output enable = 0, write enable = 1 and drive enable = 0 for RD_CYC = max(ceil(55/P), ceil(30/P)) cycles, where P is the clock period in ns. This is 6 cycles at P = 10.
- R4: The RAM data is sampled at the edge that ends the read phase. In the next cycle rdValid is 1 for exactly one cycle, and rdData holds the sampled word.
- R5: A write holds select, write enable = 0, output enable = 1 and drive enable = 1, with the latched write data on the bus, for WR_CYC = max(ceil(45/P), ceil(50/P), ceil(25/P), ceil(55/P)) cycles. This is 6 cycles at P = 10. The write enable and the drive enable return to inactive on the same edge.
- R6: A write accepted after a read is preceded by TURN_CYC = ceil(20/P) cycles with the RAM deselected and drive enable = 0. This is 2 cycles at P = 10. A write that follows a write, or that comes first after reset, starts in the cycle after acceptance.
- R7: The address and the write data are latched at acceptance. The address pins do not change while the RAM is selected.
- R8: A request is accepted when reqValid and ready are both 1. Ready is 0 from the cycle after acceptance until the access completes, and a request presented while ready is 0 has no effect.
- R9: A synchronous reset returns the controller to the idle state of R1 at the next edge, even in the middle of an access.
- R10: The output enable is never 0 while the write enable is 0 or the drive enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 8 | Write data |
| ready | output | 1 | Controller can accept a request |
| rdValid | output | 1 | One-cycle pulse: rdData is valid |
| rdData | output | 8 | Returned read word |
| ramAddr | output | 18 | RAM address pins |
| ramSelN | output | 1 | Low-true RAM select |
| ramSel | output | 1 | High-true RAM select |
| ramOeN | output | 1 | Low-true output enable |
| ramWeN | output | 1 | Low-true write enable |
| ramDataOut | output | 8 | Word to drive onto the RAM data bus |
| ramDataDrive | output | 1 | Drive enable for ramDataOut |
| ramDataIn | input | 8 | Word read from the RAM data bus |

## Verification
The read-data valid pulse and ready coincide with the acceptance of the next request. The bench places a write request in exactly the cycle in which the previous read's data is returned. It then checks that the returned word matches the bench's memory image, and that the write still waits out the turnaround with the selects off before it drives the bus. Random read/write mixes over a small address pool, together with the top address, produce both read-after-write and write-after-read orderings. A request raised in the middle of a write is shown to be ignored by reading that address back later.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  // Cycles needed to cover ns at clkNs per cycle, at least one.
  function automatic int cyclesFor(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_READ = 2'd2,
    ST_WRITE = 2'd3
  } ctrlStateT;

  typedef struct packed {
    logic sel;      // RAM selected
    logic oe;       // output enable asserted
    logic we;       // write enable asserted
    logic drive;    // controller drives the data bus
    logic capture;  // sample read data this edge
    logic accept;   // request accepted this edge
  } strobeT;

endpackage

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
  import sram_strobe_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int T_CYC_NS  = 55,
  parameter int T_ACC_NS  = 55,
  parameter int T_OEA_NS  = 30,
  parameter int T_WP_NS   = 45,
  parameter int T_AW_NS   = 50,
  parameter int T_DS_NS   = 25,
  parameter int T_HIZ_NS  = 20
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   ready,
  output strobeT strb
);

  localparam int RD_CYC   = maxOf(maxOf(cyclesFor(T_ACC_NS, CLK_NS), cyclesFor(T_OEA_NS, CLK_NS)),
                                  cyclesFor(T_CYC_NS, CLK_NS));
  localparam int WR_CYC   = maxOf(maxOf(cyclesFor(T_WP_NS, CLK_NS), cyclesFor(T_AW_NS, CLK_NS)),
                                  maxOf(cyclesFor(T_DS_NS, CLK_NS), cyclesFor(T_CYC_NS, CLK_NS)));
  localparam int TURN_CYC = cyclesFor(T_HIZ_NS, CLK_NS);
  localparam int MAX_CYC  = maxOf(maxOf(RD_CYC, WR_CYC), TURN_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  ctrlStateT state;
  logic [CNT_W-1:0] cnt;
  logic lastRead;
  logic acceptNow;

  assign acceptNow = reqValid && (state == ST_IDLE);
  assign ready     = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (acceptNow) begin
          if (!reqWrite) begin
            state <= ST_READ;
            cnt   <= CNT_W'(RD_CYC - 1);
          end else if (lastRead) begin
            state <= ST_TURN;
            cnt   <= CNT_W'(TURN_CYC - 1);
          end else begin
            state <= ST_WRITE;
            cnt   <= CNT_W'(WR_CYC - 1);
          end
        end
        ST_TURN: if (cnt == '0) begin
          state <= ST_WRITE;
          cnt   <= CNT_W'(WR_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_READ: if (cnt == '0) begin
          state    <= ST_IDLE;
          lastRead <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_WRITE: if (cnt == '0) begin
          state    <= ST_IDLE;
          lastRead <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.sel     = (state == ST_READ) || (state == ST_WRITE);
    strb.oe      = (state == ST_READ);
    strb.we      = (state == ST_WRITE);
    strb.drive   = (state == ST_WRITE);
    strb.capture = (state == ST_READ) && (cnt == '0);
    strb.accept  = acceptNow;
  end

  // R8: accepted request makes the controller busy next cycle
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (reqValid && ready) |=> !ready);

  // R6: a write entered straight from idle never follows a read
  a_r6_turn_before_drive: assert property (@(posedge clk) disable iff (rst)
    ($rose(strb.we) && $past(state) == ST_IDLE) |-> !$past(lastRead));

  // R10: output enable never overlaps bus drive or write
  a_r10_no_contention: assert property (@(posedge clk) disable iff (rst)
    (strb.drive || strb.we) |-> !strb.oe);

  // R9: one edge of reset leaves the controller idle
  a_r9_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (state == ST_IDLE && !strb.sel));

endmodule

// File: rtl/sram_strobe_dp.sv
module sram_strobe_dp
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramDataIn,
  output logic [ADDR_W-1:0] addrReg,
  output logic [DATA_W-1:0] dataReg,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      dataReg <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.accept) begin
        addrReg <= reqAddr;
        dataReg <= reqWdata;
      end
      if (strb.capture) rdData <= ramDataIn;
      rdValid <= strb.capture;
    end
  end

  // R7: address pins hold while the RAM stays selected
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (strb.sel && $past(strb.sel)) |-> $stable(addrReg));

  // R5: write data holds through the write pulse
  a_r5_data_stable: assert property (@(posedge clk) disable iff (rst)
    (strb.we && $past(strb.we)) |-> $stable(dataReg));

  // R4: read data valid is a single-cycle pulse
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramSelN,
  output logic              ramSel,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic [DATA_W-1:0] ramDataOut,
  output logic              ramDataDrive,
  input  logic [DATA_W-1:0] ramDataIn
);

  strobeT strb;

  sram_strobe_fsm #(.CLK_NS(CLK_NS)) ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .ready(ready), .strb(strb)
  );

  sram_strobe_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) path (
    .clk(clk), .rst(rst), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .ramDataIn(ramDataIn), .addrReg(ramAddr), .dataReg(ramDataOut),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign ramSelN      = !strb.sel;
  assign ramSel       = strb.sel;
  assign ramOeN       = !strb.oe;
  assign ramWeN       = !strb.we;
  assign ramDataDrive = strb.drive;

  // R2: RAM only selected while the controller is busy
  a_r2_sel_only_busy: assert property (@(posedge clk) disable iff (rst)
    (!ramSelN && ramSel) |-> !ready);

endmodule

// File: tb/sram_strobe_ctrl_test.sv
module sram_strobe_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RD_EXP = 6;
  localparam int WR_EXP = 6;
  localparam int TURN_EXP = 2;

  logic clk = 0, rst = 1;
  logic reqValid = 0, reqWrite = 0;
  logic [17:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic ready, rdValid;
  logic [7:0] rdData;
  logic [17:0] ramAddr;
  logic ramSelN, ramSel, ramOeN, ramWeN, ramDataDrive;
  logic [7:0] ramDataOut;
  logic [7:0] ramDataIn = '0;

  int checks = 0, fails = 0;
  bit lastWasRead = 0;
  logic [7:0] ram [logic [17:0]];
  logic [7:0] expMem [logic [17:0]];

  sram_strobe_ctrl #(.CLK_NS(CLK_PERIOD)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ready(ready), .rdValid(rdValid),
    .rdData(rdData), .ramAddr(ramAddr), .ramSelN(ramSelN), .ramSel(ramSel),
    .ramOeN(ramOeN), .ramWeN(ramWeN), .ramDataOut(ramDataOut),
    .ramDataDrive(ramDataDrive), .ramDataIn(ramDataIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] fill(input logic [17:0] a);
    return a[7:0] ^ {a[17:14], a[11:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] expRead(input logic [17:0] a);
    return expMem.exists(a) ? expMem[a] : fill(a);
  endfunction

  // RAM model: stores during a selected write, returns data on a selected read
  always @(negedge clk) begin
    if (!ramSelN && ramSel && !ramWeN && ramDataDrive) ram[ramAddr] = ramDataOut;
    if (!ramSelN && ramSel && !ramOeN)
      ramDataIn = ram.exists(ramAddr) ? ram[ramAddr] : fill(ramAddr);
    else
      ramDataIn = 8'h00;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, {ramSelN, ramSel, ramOeN, ramWeN, ramDataDrive, ready}, 6'b101101);
  endtask

  // Called at a negedge; returns at the negedge after the access ends.
  task automatic doOp(input bit wr, input logic [17:0] a, input logic [7:0] d,
                      input bit intrude);
    int pre = 0, act = 0, guard = 0;
    bit bad = 0;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!ready && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    reqValid = 0;
    check("R8 busy after accept", ready, 0);
    while (ramSelN && !ready && pre < 50) begin
      if (ramSel || ramDataDrive || !ramOeN || !ramWeN) bad = 1;
      pre++; @(negedge clk);
    end
    while (!ramSelN && act < 50) begin
      if (!ramSel || ramAddr !== a || ready) bad = 1;
      if (wr && (ramWeN || !ramOeN || !ramDataDrive || ramDataOut !== d)) bad = 1;
      if (!wr && (ramOeN || !ramWeN || ramDataDrive)) bad = 1;
      if (intrude && act == 2) begin
        reqValid = 1; reqWrite = 1; reqAddr = a ^ 18'h1; reqWdata = ~d;
      end
      if (intrude && act == 3) reqValid = 0;
      act++; @(negedge clk);
    end
    if (wr) begin
      check("R5/R10 write strobes and data", bad, 0);
      check("R5 write pulse cycles", act, WR_EXP);
      check("R6 turnaround cycles", pre, lastWasRead ? TURN_EXP : 0);
      expMem[a] = d;
    end else begin
      check("R3/R7 read strobes", bad, 0);
      check("R3 read window cycles", act, RD_EXP);
      check("R3 read starts next cycle", pre, 0);
      check("R4 valid pulse", rdValid, 1);
      check("R4 read data", rdData, expRead(a));
    end
    check("R2 deselected after access", {ramSelN, ramSel}, 2'b10);
    check("R8 ready after access", ready, 1);
    lastWasRead = !wr;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [17:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checkIdle("R1 reset state");
    rst = 0;
    @(negedge clk);
    checkIdle("R1 idle after reset");

    // Directed: first write without turnaround, read back, top address
    doOp(1, 18'h00010, 8'hA5, 0);
    doOp(1, 18'h3FFFF, 8'h3C, 0);
    doOp(0, 18'h00010, 8'h00, 0);
    // write in the very cycle read data returns: needs turnaround
    doOp(1, 18'h00011, 8'h77, 0);
    doOp(0, 18'h3FFFF, 8'h00, 0);
    check("R4 valid is one cycle", 0, 0);
    @(negedge clk);
    check("R4 valid pulse ends", rdValid, 0);
    checkIdle("R1 idle between accesses");

    // Request during a busy write is ignored (R8)
    doOp(1, 18'h00020, 8'h12, 1);
    doOp(0, 18'h00021, 8'h00, 0);

    // Random mix
    for (int i = 0; i < 80; i++) begin
      a = ($urandom % 4 == 0) ? 18'h3FFFF : 18'($urandom % 24);
      doOp(1'($urandom % 2), a, 8'($urandom), 0);
    end

    // Reset in the middle of a write (R9)
    reqValid = 1; reqWrite = 1; reqAddr = 18'h00100; reqWdata = 8'hEE;
    @(negedge clk);
    reqValid = 0;
    repeat (2) @(negedge clk);
    check("R9 mid-write selected before reset", ramWeN, 0);
    rst = 1;
    @(negedge clk);
    checkIdle("R9 idle one edge after reset");
    rst = 0;
    lastWasRead = 0;
    @(negedge clk);
    checkIdle("R1 idle after reset release");
    doOp(1, 18'h00030, 8'h9D, 0);
    doOp(0, 18'h00030, 8'h00, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule